// File: doc/BRIEF.md
# DMA Channel Byte Counter

This block holds the remaining byte count of a single DMA channel. Software writes the count while the channel is idle. It then raises a start request together with an operand size and a request mode. When start is requested, the block checks that the count is non-zero and a whole multiple of the operand width. If the check passes, the channel enters the running state and latches the size and the mode. If it fails, a sticky configuration-error flag is raised instead and the channel stays idle.

While running, each successful operand transfer lowers the count by the operand width in bytes. When the count reaches zero, the channel stops and a sticky done flag is set. In external-request mode a one-cycle done handshake pulse is also driven. A bus error stops the channel without touching the count, so the register still shows the count that the next access would have used.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure. Address generation and bus arbitration are handled elsewhere.

Top module: `dma_bytecnt`

## Requirements
- R1: A write pulse on `load_i` copies `load_data_i` into `count_o` at the next clock edge, but only while `started_o` is 0. A write pulse while `started_o` is 1 leaves the count unchanged.
- R2: A start pulse is accepted when all of the following hold: `started_o` is 0, `cfg_err_o` is 0, the held count is non-zero, and the count is aligned to the size. When accepted, `started_o` reads 1 after the next edge, and `size_i` and `ext_mode_i` are latched at that edge.
- R3: The size is encoded on `size_i` as 0 = byte, 1 = word, 2 = long word. While `started_o` is 1, each `xfer_ok_i` pulse that has no bus error in the same cycle lowers the count by 1, 2 or 4 for the latched size.
- R4: Starting with size 1 (word) and an odd count sets `cfg_err_o`. `started_o` stays 0 and the count is unchanged.
- R5: Starting with size 2 (long word) and a count that is not a multiple of 4 sets `cfg_err_o`. `started_o` stays 0 and the count is unchanged.
- R6: Starting with a count of zero sets `cfg_err_o` for every size, and `started_o` stays 0.
- R7: Starting with the reserved size code 3 sets `cfg_err_o`, and `started_o` stays 0.
- R8: The transfer that brings the count to zero sets `done_o` and clears `started_o` at the same edge.
- R9: When the latched mode is external (`ext_mode_i` = 1 at start), `done_hs_o` is high for exactly the one cycle in which `done_o` first reads 1. In internal mode, `done_hs_o` stays 0.
- R10: A `bus_err_i` pulse while running clears `started_o` and leaves the count and `done_o` unchanged. This holds even when `xfer_ok_i` is high in the same cycle.
- R11: While `cfg_err_o` is 1, start pulses and transfer strobes have no effect. `cfg_err_o` stays set until a `clr_cfg_i` pulse, and `done_o` stays set until a `clr_done_i` pulse.
- R12: `xfer_ok_i` pulses while `started_o` is 0 leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Write strobe for the count register |
| load_data_i | input | CNT_W | Value to write into the count register |
| start_i | input | 1 | Start request pulse |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long word, 3 reserved |
| ext_mode_i | input | 1 | 1 selects external-request mode |
| xfer_ok_i | input | 1 | One operand transfer completed without error |
| bus_err_i | input | 1 | The current transfer ended with a bus error |
| clr_done_i | input | 1 | Clears the done flag |
| clr_cfg_i | input | 1 | Clears the configuration-error flag |
| count_o | output | CNT_W | Count for the next access |
| done_o | output | 1 | Sticky completion flag |
| cfg_err_o | output | 1 | Sticky configuration-error flag |
| started_o | output | 1 | Channel is running |
| done_hs_o | output | 1 | One-cycle done handshake pulse (external mode only) |

## Verification
The main sweep tries every size code, including the reserved one, against counts from 0 to 17 in both request modes. This separates good starts from odd, misaligned, zero and reserved-size starts, and it checks every decrement step down to zero against a model that subtracts the step. In external mode the sweep also checks that the handshake lasts exactly one cycle, and in internal mode that it never appears.

Directed cases cover the remaining behaviour. A bus error that coincides with a transfer strobe shows the freeze-before-decrement rule. Writes and strobes made while running, idle or in error show that they are ignored in each state. Holding and then clearing the sticky flags checks that they stay set until software clears them.

// File: rtl/dma_bytecnt_pkg.sv
package dma_bytecnt_pkg;
  typedef enum logic [1:0] {
    OPSZ_BYTE = 2'b00,
    OPSZ_WORD = 2'b01,
    OPSZ_LONG = 2'b10,
    OPSZ_RSVD = 2'b11
  } opsz_e;
endpackage

// File: rtl/dma_cnt_check.sv
// Combinational decode: step per operand, start legality, last-transfer detect.
module dma_cnt_check
  import dma_bytecnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  opsz_e            size,
  output logic [CNT_W-1:0] step,
  output logic             cfg_bad,
  output logic             is_last
);
  logic misalign;
  logic zero_cnt;

  always_comb begin
    step     = '0;
    misalign = 1'b0;
    unique case (size)
      OPSZ_BYTE: begin step = CNT_W'(1); misalign = 1'b0;         end
      OPSZ_WORD: begin step = CNT_W'(2); misalign = cnt[0];       end
      OPSZ_LONG: begin step = CNT_W'(4); misalign = |cnt[1:0];    end
      default:   begin step = '0;        misalign = 1'b1;         end
    endcase
  end

  assign zero_cnt = (cnt == '0);
  assign cfg_bad  = zero_cnt | misalign;
  assign is_last  = (cnt == step) && (step != '0);
endmodule

// File: rtl/dma_cnt_core.sv
// The count register itself.
module dma_cnt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  input  logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load_en) cnt <= load_val;
    else if (dec_en)  cnt <= cnt - step;
  end
endmodule

// File: rtl/dma_cnt_ctrl.sv
// Channel state: running bit, sticky flags, latched size/mode, handshake.
module dma_cnt_ctrl
  import dma_bytecnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  opsz_e size_i,
  input  logic  ext_mode_i,
  input  logic  xfer_ok_i,
  input  logic  bus_err_i,
  input  logic  clr_done_i,
  input  logic  clr_cfg_i,
  input  logic  cfg_bad,
  input  logic  is_last,
  output logic  started,
  output opsz_e size_q,
  output logic  done,
  output logic  cfg_err,
  output logic  done_hs,
  output logic  dec_en
);
  logic ext_q;
  logic start_req;
  logic finish;

  assign start_req = start_i & ~started & ~cfg_err;
  assign dec_en    = started & xfer_ok_i & ~bus_err_i;
  assign finish    = dec_en & is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      size_q  <= OPSZ_BYTE;
      ext_q   <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      done_hs <= 1'b0;
    end else begin
      if (start_req) begin
        size_q <= size_i;
        ext_q  <= ext_mode_i;
      end

      if (start_req && !cfg_bad)            started <= 1'b1;
      else if (started && (bus_err_i || finish)) started <= 1'b0;

      if (start_req && cfg_bad) cfg_err <= 1'b1;
      else if (clr_cfg_i)       cfg_err <= 1'b0;

      if (finish)          done <= 1'b1;
      else if (clr_done_i) done <= 1'b0;

      done_hs <= finish & ext_q;
    end
  end

  AST_CFG_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !started); // R11
  AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_hs |=> !done_hs); // R9
  AST_HS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_hs |-> done); // R9
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !clr_cfg_i |=> cfg_err); // R11
endmodule

// File: rtl/dma_bytecnt.sv
module dma_bytecnt
  import dma_bytecnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             start_i,
  input  logic [1:0]       size_i,
  input  logic             ext_mode_i,
  input  logic             xfer_ok_i,
  input  logic             bus_err_i,
  input  logic             clr_done_i,
  input  logic             clr_cfg_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             cfg_err_o,
  output logic             started_o,
  output logic             done_hs_o
);
  opsz_e            size_in;
  opsz_e            size_q;
  opsz_e            size_sel;
  logic [CNT_W-1:0] step;
  logic             cfg_bad;
  logic             is_last;
  logic             dec_en;
  logic             load_en;

  assign size_in  = opsz_e'(size_i);
  assign size_sel = started_o ? size_q : size_in;
  assign load_en  = load_i & ~started_o;

  dma_cnt_check #(.CNT_W(CNT_W)) u_check (
    .cnt     (count_o),
    .size    (size_sel),
    .step    (step),
    .cfg_bad (cfg_bad),
    .is_last (is_last)
  );

  dma_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_data_i),
    .dec_en   (dec_en),
    .step     (step),
    .cnt      (count_o)
  );

  dma_cnt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .size_i     (size_in),
    .ext_mode_i (ext_mode_i),
    .xfer_ok_i  (xfer_ok_i),
    .bus_err_i  (bus_err_i),
    .clr_done_i (clr_done_i),
    .clr_cfg_i  (clr_cfg_i),
    .cfg_bad    (cfg_bad),
    .is_last    (is_last),
    .started    (started_o),
    .size_q     (size_q),
    .done       (done_o),
    .cfg_err    (cfg_err_o),
    .done_hs    (done_hs_o),
    .dec_en     (dec_en)
  );

  AST_BUSERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    started_o && bus_err_i |=> $stable(count_o) && !started_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !started_o && !load_i |=> $stable(count_o)); // R12
  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    started_o && !xfer_ok_i |=> $stable(count_o)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    started_o && xfer_ok_i && !bus_err_i |=> count_o < $past(count_o)); // R3
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !started_o && count_o == '0); // R8
endmodule

// File: tb/tb_dma_bytecnt.sv
module tb_dma_bytecnt;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_i = 1'b0;
  logic [CNT_W-1:0] load_data_i = '0;
  logic             start_i = 1'b0;
  logic [1:0]       size_i = 2'd0;
  logic             ext_mode_i = 1'b0;
  logic             xfer_ok_i = 1'b0;
  logic             bus_err_i = 1'b0;
  logic             clr_done_i = 1'b0;
  logic             clr_cfg_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             done_o, cfg_err_o, started_o, done_hs_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_bytecnt #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
    .start_i(start_i), .size_i(size_i), .ext_mode_i(ext_mode_i),
    .xfer_ok_i(xfer_ok_i), .bus_err_i(bus_err_i), .clr_done_i(clr_done_i),
    .clr_cfg_i(clr_cfg_i), .count_o(count_o), .done_o(done_o),
    .cfg_err_o(cfg_err_o), .started_o(started_o), .done_hs_o(done_hs_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive for one cycle at a falling edge; results are visible at the next one.
  task automatic cyc();
    @(negedge clk);
    load_i = 0; start_i = 0; xfer_ok_i = 0; bus_err_i = 0;
    clr_done_i = 0; clr_cfg_i = 0;
  endtask

  task automatic do_load(logic [CNT_W-1:0] v);
    load_i = 1; load_data_i = v; cyc();
  endtask

  task automatic do_start(int sz, bit ext);
    start_i = 1; size_i = 2'(sz); ext_mode_i = ext; cyc();
  endtask

  task automatic clear_flags();
    clr_done_i = 1; clr_cfg_i = 1; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk("R1", "reset count", count_o, 0);
    chk("R8", "reset done", done_o, 0);
    chk("R11", "reset cfg_err", cfg_err_o, 0);
    chk("R2", "reset started", started_o, 0);
    chk("R9", "reset hs", done_hs_o, 0);

    // R1: large load while idle
    do_load(32'h1234_5678);
    chk("R1", "idle load", count_o, 32'h1234_5678);

    // Sweep sizes x counts x modes
    for (int sz = 0; sz < 4; sz++) begin
      for (int c = 0; c < 18; c++) begin
        for (int ext = 0; ext < 2; ext++) begin
          bit bad;
          int stp;
          int expc;
          string rq;
          clear_flags();
          do_load(CNT_W'(c));
          bad = (c == 0) || (sz == 3) || (sz == 1 && (c % 2) != 0) ||
                (sz == 2 && (c % 4) != 0);
          rq = (c == 0) ? "R6" : (sz == 3) ? "R7" : (sz == 1) ? "R4" :
               (sz == 2) ? "R5" : "R2";
          do_start(sz, ext[0]);
          chk(rq, "start cfg_err", cfg_err_o, bad);
          chk(rq, "start started", started_o, !bad);
          chk(rq, "start count", count_o, c);
          if (bad) begin
            xfer_ok_i = 1; cyc();
            chk("R11", "strobe in error count", count_o, c);
            do_start(0, 0);
            chk("R11", "start in error started", started_o, 0);
            chk("R11", "cfg_err sticky", cfg_err_o, 1);
            clr_cfg_i = 1; cyc();
            chk("R11", "cfg_err cleared", cfg_err_o, 0);
          end else begin
            stp = 1 << sz;
            expc = c;
            while (expc > 0) begin
              xfer_ok_i = 1; size_i = 2'd3; ext_mode_i = ~ext[0]; cyc();
              expc -= stp;
              chk("R3", "step count", count_o, expc);
              if (expc == 0) begin
                chk("R8", "done at zero", done_o, 1);
                chk("R8", "stopped at zero", started_o, 0);
                chk("R9", "hs at zero", done_hs_o, ext);
                cyc();
                chk("R9", "hs one cycle", done_hs_o, 0);
                chk("R11", "done sticky", done_o, 1);
              end else begin
                chk("R8", "not done yet", done_o, 0);
                chk("R3", "still running", started_o, 1);
                chk("R9", "no early hs", done_hs_o, 0);
              end
            end
          end
        end
      end
    end

    // R10: bus error coinciding with a transfer strobe
    clear_flags();
    chk("R11", "done cleared", done_o, 0);
    do_load(12);
    do_start(1, 1);
    xfer_ok_i = 1; cyc();
    chk("R3", "word step", count_o, 10);
    xfer_ok_i = 1; bus_err_i = 1; cyc();
    chk("R10", "bus err count frozen", count_o, 10);
    chk("R10", "bus err stops", started_o, 0);
    chk("R10", "bus err no done", done_o, 0);
    chk("R10", "bus err no hs", done_hs_o, 0);
    // R12: strobes while idle are ignored
    xfer_ok_i = 1; cyc();
    xfer_ok_i = 1; cyc();
    chk("R12", "idle strobe count", count_o, 10);
    do_start(1, 1);
    chk("R2", "restart after bus err", started_o, 1);

    // R1: write while running ignored
    load_i = 1; load_data_i = 100; cyc();
    chk("R1", "load while running", count_o, 10);
    for (int k = 0; k < 5; k++) begin xfer_ok_i = 1; cyc(); end
    chk("R8", "finish after restart", done_o, 1);
    chk("R1", "count zero", count_o, 0);
    repeat (3) cyc();
    chk("R11", "done still sticky", done_o, 1);
    clr_done_i = 1; cyc();
    chk("R11", "done clear", done_o, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule